// File: doc/BRIEF.md
# Automatic Line Activation Controller

This block is the control state machine of a subscriber line interface that runs in automatic activation mode. The host writes a three-bit mode word. For power-down, ringing and on-hook transmission words, the block follows the host. For an automatic-active word, it moves among high-impedance feeding, stand-by and active states by itself, using two line detectors, so that the line draws as little power as its loop status allows.

The controller runs on a fast free-running system clock. It passes all asynchronous inputs through synchronisers: the low-power off-hook flag, the common-mode-immune off-hook flag, the ring-trip flag and the ring-frequency clock. The ring-frequency clock serves only as a slow time base. Its rising edges drive a hold timer of `WAIT_PERIODS` periods (128 by default). That timer validates off-hook in stand-by and bridges the short on-hook breaks of pulse dialling in active. The outputs are the internal state code, the line polarity and an active-low hook indication.

Top module: `line_act_ctrl`

## Requirements
- R1: While `rst_n` is low, the state code is power-down (0), `pol_rev_o` is 0 and `det_n_o` is 1.
- R2: `mode_word` is decoded as {D0,D1,D2}, with bit 2 = D0. 000 selects power-down (state 0), 001 selects ringing (state 1), 01x selects on-hook transmission (state 2), and 1xx selects the automatic behaviour, which is entered in high-impedance feeding (state 3). A change to a different group takes effect at the first clock edge after the change.
- R3: High-impedance feeding always drives `pol_rev_o`=0 and ignores the immune off-hook flag. It never goes straight to active. When the synchronised low-power off-hook flag is high, it moves to stand-by (state 4).
- R4: In stand-by, a high immune off-hook flag moves the block to active (state 5). Otherwise, when `WAIT_PERIODS` rising edges of the ring clock have been counted since stand-by was entered, the block returns to high-impedance feeding.
- R5: In automatic active, `det_n_o` is the inverse of the synchronised immune off-hook flag. When that flag falls, the active state is held until `WAIT_PERIODS` ring-clock rising edges have been counted, and then high-impedance feeding is entered.
- R6: If off-hook returns during the hold window, the block stays active with `det_n_o` low, and a later on-hook starts a full new window.
- R7: Polarity is reverse (`pol_rev_o`=1) only for word 110 in the automatic states stand-by and active, and for word 010 in on-hook transmission and in the active state entered from it.
- R8: In on-hook transmission, a high immune off-hook flag moves the block to active with `det_n_o` low. After on-hook has lasted `WAIT_PERIODS` ring-clock rising edges, the block returns to on-hook transmission.
- R9: In ringing, a ring-trip moves the block to active and latches `det_n_o` low until the mode word changes. The polarity in ringing and after the trip is the one that was driven just before ringing was selected.
- R10: A change on a detector flag reaches the state code at the third clock edge after the change.
- R11: A mode-word change within the same group, such as a polarity change in automatic or on-hook transmission words, does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 3 | Host mode word {D0,D1,D2}, synchronous to clk |
| oh_lp_a | input | 1 | Off-hook flag from the low-power detector, asynchronous |
| oh_imm_a | input | 1 | Off-hook flag from the common-mode-immune detector, asynchronous |
| ring_trip_a | input | 1 | Ring-trip flag, asynchronous |
| ckring_a | input | 1 | Ring-frequency clock used as time base, asynchronous |
| state_o | output | 3 | Internal state code: 0 power-down, 1 ringing, 2 on-hook transmission, 3 high-impedance, 4 stand-by, 5 active |
| pol_rev_o | output | 1 | 1 = reverse line polarity |
| det_n_o | output | 1 | Hook indication, low = off-hook or ring-trip latched |

## Verification
Results arrive at different times:
- A mode-word change appears on the state code one clock edge later.
- A detector flag takes three edges: two synchroniser flops, then the state register.
- In active, `det_n_o` follows the immune flag two edges after it changes.
- A ring-clock rising edge is counted at the third edge, and a window that expires changes state at the fourth.

The bench drives inputs on falling edges and samples only on falling edges, leaving several cycles of margin after every stimulus. For the window boundaries, it checks the state after the second-to-last counted period, while the state must still hold, and again after the last one, when it must change.

// File: rtl/line_act_pkg.sv
package line_act_pkg;

   typedef enum logic [2:0] {
      ST_PDN  = 3'd0,
      ST_RING = 3'd1,
      ST_OHT  = 3'd2,
      ST_HIZ  = 3'd3,
      ST_SBY  = 3'd4,
      ST_ACT  = 3'd5
   } state_t;

   typedef enum logic [1:0] {
      G_PDN,
      G_RING,
      G_OHT,
      G_AUTO
   } grp_t;

   localparam int WORD_W = 3;

   // Word layout {D0,D1,D2}: bit 2 selects automatic behaviour.
   function automatic grp_t word_grp(input logic [WORD_W-1:0] w);
      if (w[2])      return G_AUTO;
      else if (w[1]) return G_OHT;
      else if (w[0]) return G_RING;
      else           return G_PDN;
   endfunction

   function automatic state_t grp_entry(input grp_t g);
      case (g)
         G_RING:  return ST_RING;
         G_OHT:   return ST_OHT;
         G_AUTO:  return ST_HIZ;
         default: return ST_PDN;
      endcase
   endfunction

endpackage

// File: rtl/line_act_sync.sv
module line_act_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("line_act_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din[b]};
      end
      assign dout[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/line_act_timer.sv
module line_act_timer #(
   parameter int LIMIT     = 128,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic expired
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("line_act_timer: LIMIT must be at least 2");
   end

   logic          tick_d;
   logic          edge_seen;
   logic [CW-1:0] cnt;

   if (RISE_EDGE) begin : g_rise
      assign edge_seen = tick & ~tick_d;
   end else begin : g_fall
      assign edge_seen = ~tick & tick_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_d <= 1'b0;
         cnt    <= '0;
      end else begin
         tick_d <= tick;
         if (clr)
            cnt <= '0;
         else if (edge_seen && cnt != LIM_V)
            cnt <= cnt + 1'b1;
      end
   end

   assign expired = (cnt == LIM_V);

endmodule

// File: rtl/line_act_fsm.sv
module line_act_fsm
   import line_act_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] mode_word,
   input  logic              oh_lp,
   input  logic              oh_imm,
   input  logic              rt,
   input  logic              expired,
   output state_t            state_q,
   output logic              tmr_clr,
   output logic              pol_rev,
   output logic              det_n
);

   localparam logic [WORD_W-1:0] W_AUTO_REV = 3'b110;
   localparam logic [WORD_W-1:0] W_OHT_REV  = 3'b010;

   state_t            state_d;
   logic [WORD_W-1:0] word_q;
   logic              rt_lat;
   logic              pol_hold;
   logic              word_chg;
   grp_t              g_cur;
   grp_t              g_new;

   assign word_chg = (mode_word != word_q);
   assign g_cur    = word_grp(word_q);
   assign g_new    = word_grp(mode_word);

   always_comb begin
      state_d = state_q;
      if (word_chg && g_new != g_cur) begin
         state_d = grp_entry(g_new);
      end else begin
         case (state_q)
            ST_HIZ:  if (oh_lp) state_d = ST_SBY;
            ST_SBY: begin
               if (oh_imm)       state_d = ST_ACT;
               else if (expired) state_d = ST_HIZ;
            end
            ST_ACT: begin
               if (g_cur != G_RING && !oh_imm && expired)
                  state_d = (g_cur == G_OHT) ? ST_OHT : ST_HIZ;
            end
            ST_OHT:  if (oh_imm) state_d = ST_ACT;
            ST_RING: if (rt)     state_d = ST_ACT;
            ST_PDN:  state_d = ST_PDN;
            default: state_d = ST_PDN;
         endcase
      end
   end

   assign tmr_clr = (state_d != state_q) || (state_q == ST_ACT && oh_imm);

   always_comb begin
      case (state_q)
         ST_SBY:  pol_rev = (word_q == W_AUTO_REV);
         ST_OHT:  pol_rev = (word_q == W_OHT_REV);
         ST_RING: pol_rev = pol_hold;
         ST_ACT: begin
            case (g_cur)
               G_RING:  pol_rev = pol_hold;
               G_OHT:   pol_rev = (word_q == W_OHT_REV);
               G_AUTO:  pol_rev = (word_q == W_AUTO_REV);
               default: pol_rev = 1'b0;
            endcase
         end
         default: pol_rev = 1'b0;
      endcase
   end

   assign det_n = ~(rt_lat | (state_q == ST_ACT && g_cur != G_RING && oh_imm));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_PDN;
         word_q   <= '0;
         rt_lat   <= 1'b0;
         pol_hold <= 1'b0;
      end else begin
         state_q <= state_d;
         word_q  <= mode_word;
         if (word_chg)
            rt_lat <= 1'b0;
         else if (state_q == ST_RING && rt)
            rt_lat <= 1'b1;
         if (g_cur != G_RING)
            pol_hold <= pol_rev;
      end
   end

endmodule

// File: rtl/line_act_ctrl.sv
module line_act_ctrl #(
   parameter int WAIT_PERIODS = 128,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_word,
   input  logic       oh_lp_a,
   input  logic       oh_imm_a,
   input  logic       ring_trip_a,
   input  logic       ckring_a,
   output logic [2:0] state_o,
   output logic       pol_rev_o,
   output logic       det_n_o
);
   import line_act_pkg::*;

   localparam int N_ASYNC = 4;

   if (WAIT_PERIODS < 2) begin : g_bad_wait
      $error("line_act_ctrl: WAIT_PERIODS must be at least 2");
   end

   logic [N_ASYNC-1:0] async_in;
   logic [N_ASYNC-1:0] sync_out;
   logic               oh_lp_s;
   logic               oh_imm_s;
   logic               rt_s;
   logic               ck_s;
   logic               tmr_clr;
   logic               expired;
   state_t             state_q;

   assign async_in = {ckring_a, ring_trip_a, oh_imm_a, oh_lp_a};
   assign {ck_s, rt_s, oh_imm_s, oh_lp_s} = sync_out;

   line_act_sync #(
      .WIDTH  (N_ASYNC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (async_in),
      .dout  (sync_out)
   );

   line_act_timer #(
      .LIMIT     (WAIT_PERIODS),
      .RISE_EDGE (1'b1)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ck_s),
      .clr     (tmr_clr),
      .expired (expired)
   );

   line_act_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_word (mode_word),
      .oh_lp     (oh_lp_s),
      .oh_imm    (oh_imm_s),
      .rt        (rt_s),
      .expired   (expired),
      .state_q   (state_q),
      .tmr_clr   (tmr_clr),
      .pol_rev   (pol_rev_o),
      .det_n     (det_n_o)
   );

   assign state_o = state_q;

endmodule

// File: rtl/line_act_chk.sv
module line_act_chk
   import line_act_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] state_o,
   input logic       pol_rev_o,
   input logic       det_n_o,
   input logic       oh_imm_s
);

   // R2: power-down drives the idle outputs
   a_r2_pdn_idle: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_PDN |-> (det_n_o && !pol_rev_o));

   // R3: high-impedance feeding is always direct polarity
   a_r3_hiz_direct: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_HIZ |-> !pol_rev_o);

   // R3: active is only reached from high impedance through stand-by
   a_r3_hiz_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_HIZ |=> state_o != ST_ACT);

   // R4: confirmed off-hook in stand-by leaves the power-saving states
   a_r4_sby_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_SBY && oh_imm_s) |=> (state_o != ST_SBY && state_o != ST_HIZ));

   // R5: hook indication is only low in active
   a_r5_det_only_act: assert property (@(posedge clk) disable iff (!rst_n)
      !det_n_o |-> state_o == ST_ACT);

endmodule

bind line_act_ctrl line_act_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .state_o   (state_o),
   .pol_rev_o (pol_rev_o),
   .det_n_o   (det_n_o),
   .oh_imm_s  (oh_imm_s)
);

// File: tb/line_act_ctrl_test.sv
module line_act_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_word = 3'b000;
   logic       oh_lp_a = 1'b0;
   logic       oh_imm_a = 1'b0;
   logic       ring_trip_a = 1'b0;
   logic       ckring_a = 1'b0;
   logic [2:0] state_o;
   logic       pol_rev_o;
   logic       det_n_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   localparam logic [2:0] S_PDN = 3'd0, S_RING = 3'd1, S_OHT = 3'd2,
                          S_HIZ = 3'd3, S_SBY = 3'd4, S_ACT = 3'd5;

   always #5ns clk = ~clk;

   line_act_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_word   (mode_word),
      .oh_lp_a     (oh_lp_a),
      .oh_imm_a    (oh_imm_a),
      .ring_trip_a (ring_trip_a),
      .ckring_a    (ckring_a),
      .state_o     (state_o),
      .pol_rev_o   (pol_rev_o),
      .det_n_o     (det_n_o)
   );

   // {word, lp, imm, rt, exp_state, exp_pol, exp_det_n}
   localparam int NV = 16;
   localparam logic [10:0] VEC [NV] = '{
      {3'b000, 1'b0, 1'b0, 1'b0, S_PDN,  1'b0, 1'b1},  // R2
      {3'b001, 1'b0, 1'b0, 1'b0, S_RING, 1'b0, 1'b1},  // R2
      {3'b001, 1'b0, 1'b0, 1'b1, S_ACT,  1'b0, 1'b0},  // R9 trip
      {3'b001, 1'b0, 1'b0, 1'b0, S_ACT,  1'b0, 1'b0},  // R9 latched
      {3'b011, 1'b0, 1'b0, 1'b0, S_OHT,  1'b0, 1'b1},  // R9 release, R2
      {3'b010, 1'b0, 1'b0, 1'b0, S_OHT,  1'b1, 1'b1},  // R7 R11
      {3'b010, 1'b0, 1'b1, 1'b0, S_ACT,  1'b1, 1'b0},  // R8
      {3'b100, 1'b0, 1'b1, 1'b0, S_HIZ,  1'b0, 1'b1},  // R2 R3
      {3'b110, 1'b0, 1'b1, 1'b0, S_HIZ,  1'b0, 1'b1},  // R3 direct
      {3'b110, 1'b1, 1'b1, 1'b0, S_ACT,  1'b1, 1'b0},  // R4 R7
      {3'b100, 1'b1, 1'b1, 1'b0, S_ACT,  1'b0, 1'b0},  // R11
      {3'b110, 1'b1, 1'b1, 1'b0, S_ACT,  1'b1, 1'b0},  // R7
      {3'b001, 1'b1, 1'b1, 1'b0, S_RING, 1'b1, 1'b1},  // R9 held pol
      {3'b001, 1'b1, 1'b1, 1'b1, S_ACT,  1'b1, 1'b0},  // R9
      {3'b001, 1'b0, 1'b0, 1'b0, S_ACT,  1'b1, 1'b0},  // R9 latched
      {3'b100, 1'b0, 1'b0, 1'b0, S_HIZ,  1'b0, 1'b1}   // R2
   };

   function automatic string vec_tag(input int i);
      case (i)
         2, 3, 4, 12, 13, 14: return "R9";
         5, 11:               return "R7";
         6:                   return "R8";
         7, 8:                return "R3";
         9:                   return "R4";
         10:                  return "R11";
         default:             return "R2";
      endcase
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulses(input int n);
      for (int k = 0; k < n; k++) begin
         ckring_a = 1'b1;
         step(4);
         ckring_a = 1'b0;
         step(4);
      end
   endtask

   task automatic chk(input string tag, input logic [2:0] st,
                      input logic pol, input logic dn);
      n_tests++;
      if (state_o !== st || pol_rev_o !== pol || det_n_o !== dn) begin
         n_fail++;
         $display("FAIL %s: state=%0d pol=%0b det_n=%0b expected state=%0d pol=%0b det_n=%0b",
                  tag, state_o, pol_rev_o, det_n_o, st, pol, dn);
      end
   endtask

   task automatic reach_act(input logic [2:0] w);
      mode_word = w;
      oh_lp_a   = 1'b1;
      oh_imm_a  = 1'b1;
      step(8);
   endtask

   initial begin
      step(3);
      chk("R1 reset", S_PDN, 1'b0, 1'b1);
      rst_n = 1'b1;
      step(2);

      for (int i = 0; i < NV; i++) begin
         mode_word   = VEC[i][10:8];
         oh_lp_a     = VEC[i][7];
         oh_imm_a    = VEC[i][6];
         ring_trip_a = VEC[i][5];
         step(8);
         chk(vec_tag(i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
      end

      // R4: stand-by window expires without confirmation
      oh_lp_a = 1'b1; oh_imm_a = 1'b0;
      step(8);
      chk("R4 enter sby", S_SBY, 1'b0, 1'b1);
      oh_lp_a = 1'b0;
      step(4);
      pulses(127);
      step(2);
      chk("R4 window open", S_SBY, 1'b0, 1'b1);
      pulses(1);
      step(2);
      chk("R4 window expired", S_HIZ, 1'b0, 1'b1);

      // R5: hold after on-hook
      reach_act(3'b100);
      chk("R5 active", S_ACT, 1'b0, 1'b0);
      oh_lp_a = 1'b0; oh_imm_a = 1'b0;
      step(4);
      chk("R5 det high at once", S_ACT, 1'b0, 1'b1);
      pulses(127);
      step(2);
      chk("R5 still held", S_ACT, 1'b0, 1'b1);
      pulses(1);
      step(2);
      chk("R5 back to hiz", S_HIZ, 1'b0, 1'b1);

      // R6: dialling break inside the hold window
      reach_act(3'b100);
      oh_lp_a = 1'b0; oh_imm_a = 1'b0;
      step(4);
      pulses(100);
      oh_imm_a = 1'b1;
      step(6);
      chk("R6 off-hook return", S_ACT, 1'b0, 1'b0);
      oh_imm_a = 1'b0;
      step(4);
      pulses(127);
      step(2);
      chk("R6 window restarted", S_ACT, 1'b0, 1'b1);
      pulses(1);
      step(2);
      chk("R6 final expiry", S_HIZ, 1'b0, 1'b1);

      // R8: on-hook transmission hold returns to on-hook transmission
      mode_word = 3'b011;
      step(4);
      oh_imm_a = 1'b1;
      step(8);
      chk("R8 off-hook active", S_ACT, 1'b0, 1'b0);
      oh_imm_a = 1'b0;
      step(4);
      pulses(128);
      step(2);
      chk("R8 back to oht", S_OHT, 1'b0, 1'b1);

      // R10: flag latency through synchroniser and state register
      mode_word = 3'b100;
      step(4);
      oh_lp_a = 1'b1;
      step(2);
      chk("R10 not yet", S_HIZ, 1'b0, 1'b1);
      step(1);
      chk("R10 third edge", S_SBY, 1'b0, 1'b1);

      // R1: reset in the middle of operation
      reach_act(3'b110);
      chk("R1 pre-reset active", S_ACT, 1'b1, 1'b0);
      rst_n = 1'b0;
      step(2);
      chk("R1 reset mid-run", S_PDN, 1'b0, 1'b1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule